// File: doc/BRIEF.md
# TLB-Backed Page Translation Unit

This block turns a virtual address into a physical address for fixed-size pages. The low bits of the address are the in-page offset and pass through unchanged. The high bits form the page number, which is mapped to a frame number. An eight-entry fully associative buffer compares the page number against every stored tag at once. When a tag matches, the frame number is returned in the same cycle and memory is not touched.

When no tag matches, a small controller takes over. It first compares the page number against a table-length input. It then fetches the table entry from memory at the table base plus the page number, using a request/valid port whose latency may vary. The entry's valid bit decides whether the access translates or traps. A valid entry is written into the buffer in round-robin order; an invalid one is never stored.

A flush input empties the buffer in one cycle and abandons any miss in progress. Two counters, one for hits and one for misses, let a test measure the hit ratio.

Top module: `tlb_xlat`

## Requirements
- R1: `PAGE_BYTES` is a power of two from 512 to 8192, and OFF_W = log2(PAGE_BYTES). The offset is `reqVaddr[OFF_W-1:0]` and the page number is the bits above it. A successful translation drives `respPaddr = {frame, offset}`.
- R2: While `reqReady` is high, a request whose page number matches a valid buffer entry gives `respValid=1` and `respFault=0` in the same cycle, with the stored frame, and leaves `memReq` low.
- R3: At most one buffer entry matches any page number.
- R4: A missed request is checked against the table length in the cycle after it is accepted. If the page number is greater than or equal to `ptLen`, that cycle gives `respValid=1`, `respFault=1` and `respPaddr=0`, with no memory request.
- R5: An in-bounds miss raises `memReq` from the second cycle after acceptance, with `memAddr = ptBase + page number`. `memReq` stays high until `memValid` arrives, and the response is given in that same cycle. The table entry layout is: bit PFN_W is the valid bit, and bits PFN_W-1:0 are the frame.
- R6: A fetched entry with its valid bit at 0 gives `respFault=1` and `respPaddr=0`. It is not installed, so the next access to that page misses again.
- R7: A valid fetched entry is written into the slot named by a victim pointer. The pointer starts at 0 after reset, advances by one on each fill and wraps after the last of 8 slots. A flush does not move the pointer.
- R8: `flush` invalidates every entry by the next cycle and abandons a miss in progress, which then gives no response. `reqReady` is low while `flush` is high.
- R9: `reqReady` is low from the acceptance of a miss until its response or abandonment, so only one miss is outstanding at a time.
- R10: `hitCount` increments once per hit response. `missCount` increments once per accepted miss.
- R11: After reset, `reqReady` is 1, `respValid` and `memReq` are 0, both counters are 0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all buffer entries and abandon a pending miss |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Unit can accept a request |
| reqVaddr | input | VA_W | Virtual address |
| ptBase | input | MA_W | Page table base address |
| ptLen | input | VPN_W+1 | Number of legal page-table entries |
| respValid | output | 1 | Response strobe |
| respFault | output | 1 | Translation trapped (out of range or invalid entry) |
| respPaddr | output | PA_W | Physical address, zero on fault |
| memReq | output | 1 | Table-entry read request, held until memValid |
| memAddr | output | MA_W | Table-entry address |
| memValid | input | 1 | Table-entry data is present |
| memData | input | PFN_W+1 | Table entry: valid bit above the frame |
| hitCount | output | CNT_W | Hit counter |
| missCount | output | CNT_W | Miss counter |

## Verification
A hit is due in the cycle the request is driven. The bench drives on the falling edge and samples one nanosecond later, before the next rising edge commits anything. A bounds fault is due one cycle after acceptance, and a table-entry response is due exactly in the cycle the memory model raises `memValid`. The bench therefore steps one falling edge at a time and, before the response, checks that no response appears early and that `memReq` and `memAddr` hold. Flush effects are due on the next edge, so they are checked one cycle later through a response that is missing and a page that misses again.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BOUND = 2'd1,
    ST_FETCH = 2'd2
  } xlatState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic latchReq;   // capture page number and offset of a missed request
    logic fill;       // install fetched entry at the victim slot
    logic flushAll;   // clear all entry valid bits
    logic fromMem;    // response address built from fetched entry
    logic countHit;
    logic countMiss;
  } xlatStrobe_t;

endpackage

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int PA_W       = 16,
  parameter int PAGE_BYTES = 1024,
  parameter int TLB_N      = 8,
  parameter int MA_W       = 12,
  parameter int CNT_W      = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int VPN_W     = VA_W - OFF_W,
  localparam int PFN_W     = PA_W - OFF_W,
  localparam int IDX_W     = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlatStrobe_t       st,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [MA_W-1:0]   ptBase,
  input  logic [VPN_W:0]    ptLen,
  input  logic [PFN_W:0]    memData,
  output logic              hit,
  output logic              beyondLen,
  output logic              pteValid,
  output logic [PA_W-1:0]   dpPaddr,
  output logic [MA_W-1:0]   memAddr,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);

  logic [VPN_W-1:0] reqVpn;
  logic [OFF_W-1:0] reqOff;
  assign reqVpn = reqVaddr[VA_W-1:OFF_W];
  assign reqOff = reqVaddr[OFF_W-1:0];

  logic [VPN_W-1:0] tagQ   [TLB_N];
  logic [PFN_W-1:0] pfnQ   [TLB_N];
  logic             validQ [TLB_N];
  logic [TLB_N-1:0] validVec;
  logic [TLB_N-1:0] matchVec;
  logic [PFN_W-1:0] hitPfn;
  logic [IDX_W-1:0] victimQ;
  logic [VPN_W-1:0] vpnQ;
  logic [OFF_W-1:0] offQ;

  // one slot per generate step: storage and parallel compare
  for (genvar g = 0; g < TLB_N; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        tagQ[g]   <= '0;
        pfnQ[g]   <= '0;
      end else if (st.flushAll) begin
        validQ[g] <= 1'b0;
      end else if (st.fill && victimQ == IDX_W'(g)) begin
        validQ[g] <= 1'b1;
        tagQ[g]   <= vpnQ;
        pfnQ[g]   <= memData[PFN_W-1:0];
      end
    end
    assign validVec[g] = validQ[g];
    assign matchVec[g] = validQ[g] && (tagQ[g] == reqVpn);
  end

  always_comb begin
    hitPfn = '0;
    for (int i = 0; i < TLB_N; i++) begin
      if (matchVec[i]) hitPfn = hitPfn | pfnQ[i];
    end
  end
  assign hit = |matchVec;

  // round-robin victim pointer, untouched by flush
  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimQ <= '0;
    end else if (st.fill) begin
      victimQ <= (victimQ == IDX_W'(TLB_N - 1)) ? '0 : victimQ + 1'b1;
    end
  end

  // missed-request registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ <= '0;
      offQ <= '0;
    end else if (st.latchReq) begin
      vpnQ <= reqVpn;
      offQ <= reqOff;
    end
  end

  assign beyondLen = ({1'b0, vpnQ} >= ptLen);
  assign memAddr   = ptBase + MA_W'(vpnQ);
  assign pteValid  = memData[PFN_W];
  assign dpPaddr   = st.fromMem ? {memData[PFN_W-1:0], offQ} : {hitPfn, reqOff};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCount  <= '0;
      missCount <= '0;
    end else begin
      if (st.countHit)  hitCount  <= hitCount + 1'b1;
      if (st.countMiss) missCount <= missCount + 1'b1;
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec)); // R3

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    st.flushAll |=> (validVec == '0)); // R8

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    st.fill |=> validVec[$past(victimQ)]); // R7

  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rstN)
    !(st.countHit && st.countMiss)); // R10

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flush,
  input  logic        reqValid,
  input  logic        hit,
  input  logic        beyondLen,
  input  logic        pteValid,
  input  logic        memValid,
  output xlatStrobe_t st,
  output logic        reqReady,
  output logic        respValid,
  output logic        respFault,
  output logic        memReq
);

  xlatState_e stateQ, stateD;
  logic       accept;

  assign reqReady = (stateQ == ST_IDLE) && !flush;
  assign accept   = reqValid && reqReady;

  always_comb begin
    stateD      = stateQ;
    st          = '0;
    st.flushAll = flush;
    respValid   = 1'b0;
    respFault   = 1'b0;
    memReq      = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (accept) begin
          if (hit) begin
            respValid   = 1'b1;
            st.countHit = 1'b1;
          end else begin
            st.latchReq  = 1'b1;
            st.countMiss = 1'b1;
            stateD       = ST_BOUND;
          end
        end
      end
      ST_BOUND: begin
        if (flush) begin
          stateD = ST_IDLE;
        end else if (beyondLen) begin
          respValid = 1'b1;
          respFault = 1'b1;
          stateD    = ST_IDLE;
        end else begin
          stateD = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (flush) begin
          stateD = ST_IDLE;
        end else if (memValid) begin
          respValid  = 1'b1;
          st.fromMem = 1'b1;
          respFault  = !pteValid;
          st.fill    = pteValid;
          stateD     = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid && !flush) |=> memReq); // R5

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady); // R9

  AST_NO_FILL_ON_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> !st.fill); // R6

  AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (flush && stateQ != ST_IDLE) |-> !respValid); // R8

endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat
  import xlat_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int PA_W       = 16,
  parameter int PAGE_BYTES = 1024,
  parameter int TLB_N      = 8,
  parameter int MA_W       = 12,
  parameter int CNT_W      = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int VPN_W     = VA_W - OFF_W,
  localparam int PFN_W     = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [MA_W-1:0]  ptBase,
  input  logic [VPN_W:0]   ptLen,
  output logic             respValid,
  output logic             respFault,
  output logic [PA_W-1:0]  respPaddr,
  output logic             memReq,
  output logic [MA_W-1:0]  memAddr,
  input  logic             memValid,
  input  logic [PFN_W:0]   memData,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);

  if (PAGE_BYTES < 512 || PAGE_BYTES > 8192 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : gBadPage
    $error("PAGE_BYTES must be a power of two in 512..8192"); // R1
  end

  xlatStrobe_t   st;
  logic          hit, beyondLen, pteValid;
  logic [PA_W-1:0] dpPaddr;

  xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid),
    .hit(hit), .beyondLen(beyondLen), .pteValid(pteValid), .memValid(memValid),
    .st(st), .reqReady(reqReady), .respValid(respValid),
    .respFault(respFault), .memReq(memReq)
  );

  xlat_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BYTES(PAGE_BYTES),
    .TLB_N(TLB_N), .MA_W(MA_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqVaddr(reqVaddr),
    .ptBase(ptBase), .ptLen(ptLen), .memData(memData),
    .hit(hit), .beyondLen(beyondLen), .pteValid(pteValid),
    .dpPaddr(dpPaddr), .memAddr(memAddr),
    .hitCount(hitCount), .missCount(missCount)
  );

  assign respPaddr = respFault ? '0 : dpPaddr;

endmodule

// File: tb/tlb_xlat_tb_top.sv
`timescale 1ns/1ps
module tlb_xlat_tb_top;

  localparam int PB      = 1024;
  localparam int PT_BASE = 16;
  localparam int PT_LEN  = 40;

  logic        clk = 1'b0;
  logic        rstN, flush, reqValid, memValid;
  logic [15:0] reqVaddr;
  logic [11:0] ptBase;
  logic [6:0]  ptLen;
  logic [6:0]  memData;
  logic        reqReady, respValid, respFault, memReq;
  logic [15:0] respPaddr, hitCount, missCount;
  logic [11:0] memAddr;

  always #10 clk = ~clk;

  tlb_xlat dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .ptBase(ptBase), .ptLen(ptLen), .respValid(respValid),
    .respFault(respFault), .respPaddr(respPaddr), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .hitCount(hitCount), .missCount(missCount)
  );

  int checks = 0;
  int errors = 0;
  int expHit = 0;
  int expMiss = 0;
  int mTag [8];
  int mFrm [8];
  bit mVal [8];
  int mPtr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pteOk(input int a);
    return (a % 5) != 3;
  endfunction
  function automatic int pteFrm(input int a);
    return (a * 7 + 3) % 64;
  endfunction

  function automatic int mLookup(input int vpn);
    for (int i = 0; i < 8; i++) if (mVal[i] && mTag[i] == vpn) return i;
    return -1;
  endfunction

  // memory responder: variable latency, answers only while memReq is held
  initial begin
    int waitCnt;
    int lat;
    waitCnt  = 0;
    memValid = 1'b0;
    memData  = '0;
    forever begin
      @(negedge clk);
      memValid = 1'b0;
      if (rstN && memReq) begin
        lat = (int'(memAddr) % 3) + 1;
        if (waitCnt == lat) begin
          memValid = 1'b1;
          memData  = {pteOk(int'(memAddr)), 6'(pteFrm(int'(memAddr)))};
          waitCnt  = 0;
        end else begin
          waitCnt++;
        end
      end else begin
        waitCnt = 0;
      end
    end
  end

  task automatic access(input int vpn, input int off, input string tag);
    int idx;
    int n;
    int a;
    idx = mLookup(vpn);
    @(negedge clk);
    reqValid = 1'b1;
    reqVaddr = 16'(vpn * PB + off);
    #1;
    chk(reqReady == 1'b1, {tag, " R9 ready when idle"}, reqReady, 1);
    if (idx >= 0) begin
      chk(respValid && !respFault, {tag, " R2 hit response"}, respValid, 1);
      chk(respPaddr == 16'(mFrm[idx] * PB + off), {tag, " R1 R3 hit address"}, respPaddr, mFrm[idx] * PB + off);
      chk(memReq == 1'b0, {tag, " R2 no memory on hit"}, memReq, 0);
      expHit++;
      @(negedge clk);
      reqValid = 1'b0;
    end else begin
      chk(respValid == 1'b0, {tag, " R2 R7 miss gives no immediate response"}, respValid, 0);
      expMiss++;
      @(negedge clk);
      reqValid = 1'b0;
      #1;
      if (vpn >= PT_LEN) begin
        chk(respValid && respFault, {tag, " R4 bound fault"}, respFault, 1);
        chk(respPaddr == 0, {tag, " R4 fault address"}, respPaddr, 0);
        chk(memReq == 1'b0, {tag, " R4 no memory access"}, memReq, 0);
      end else begin
        chk(!respValid && !reqReady, {tag, " R9 busy during miss"}, reqReady, 0);
        n = 0;
        do begin
          @(negedge clk);
          #1;
          n++;
          if (!respValid) begin
            chk(memReq && memAddr == 12'(PT_BASE + vpn), {tag, " R5 request held"}, memAddr, PT_BASE + vpn);
          end
        end while (!respValid && n < 20);
        a = PT_BASE + vpn;
        chk(memValid == 1'b1, {tag, " R5 response with data"}, memValid, 1);
        if (pteOk(a)) begin
          chk(!respFault && respPaddr == 16'(pteFrm(a) * PB + off), {tag, " R5 fetched translation"}, respPaddr, pteFrm(a) * PB + off);
          mTag[mPtr] = vpn;
          mFrm[mPtr] = pteFrm(a);
          mVal[mPtr] = 1'b1;
          mPtr = (mPtr + 1) % 8;
        end else begin
          chk(respFault && respPaddr == 0, {tag, " R6 invalid entry traps"}, respFault, 1);
        end
      end
    end
  endtask

  task automatic modelFlush();
    for (int i = 0; i < 8; i++) mVal[i] = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; flush = 1'b0; reqValid = 1'b0; reqVaddr = '0;
    ptBase = 12'(PT_BASE); ptLen = 7'(PT_LEN);
    for (int i = 0; i < 8; i++) begin mVal[i] = 1'b0; mTag[i] = 0; mFrm[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(reqReady && !respValid && !memReq, "R11 reset outputs", reqReady, 1);
    chk(hitCount == 0 && missCount == 0, "R11 reset counters", hitCount + missCount, 0);

    // sweep every page, legal and illegal, with scattered offsets
    for (int v = 0; v < 64; v++) access(v, (v * 37) % PB, "sweep");
    // offset extremes on low pages
    for (int v = 0; v < 12; v++) access(v, (v % 2) ? PB - 1 : 0, "edges");
    // repeated pages: mostly hits
    for (int r = 0; r < 5; r++) for (int v = 30; v < 34; v++) access(v, r * 100 + v, "repeat");
    // invalid page twice: must miss both times
    access(2, 5, "inv1");
    access(2, 6, "inv2 R6");

    // idle flush
    @(negedge clk); flush = 1'b1; #1;
    chk(reqReady == 1'b0, "R8 not ready during flush", reqReady, 0);
    @(negedge clk); flush = 1'b0;
    modelFlush();
    access(31, 7, "post-flush R8");

    // flush during a pending fetch
    @(negedge clk); reqValid = 1'b1; reqVaddr = 16'(3 * PB + 9); expMiss++;
    @(negedge clk); reqValid = 1'b0;
    @(negedge clk); #1;
    chk(memReq == 1'b1, "R5 fetch started", memReq, 1);
    flush = 1'b1;
    @(negedge clk); flush = 1'b0; #1;
    chk(!respValid && !memReq, "R8 miss abandoned", respValid, 0);
    modelFlush();
    repeat (4) begin
      @(negedge clk); #1;
      chk(respValid == 1'b0, "R8 no late response", respValid, 0);
    end
    access(31, 8, "flushed entry R8");

    // round-robin: nine valid pages into eight slots, then the oldest
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    modelFlush();
    foreach (mTag[i]) mTag[i] = mTag[i];
    access(0, 1, "rr"); access(1, 1, "rr"); access(3, 1, "rr");
    access(4, 1, "rr"); access(5, 1, "rr"); access(6, 1, "rr");
    access(8, 1, "rr"); access(9, 1, "rr"); access(10, 1, "rr");
    access(0, 2, "R7 evicted oldest");
    access(3, 3, "R7 kept");
    access(39, 4, "R4 last legal");
    access(40, 4, "R4 first illegal");

    @(negedge clk); #1;
    chk(hitCount == 16'(expHit), "R10 hit counter", hitCount, expHit);
    chk(missCount == 16'(expMiss), "R10 miss counter", missCount, expMiss);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule